// File: doc/BRIEF.md
# Phase-Programmable Integer Clock Divider

This block divides one of two selectable input clocks by any integer from 1 to 64. The output keeps a 50% duty cycle for odd ratios as well as even ones, because both edges of the input clock are used. A second field delays the first output edge after a synchronising release, in steps of half an input period, from 0 to 63 steps. One block drives one output group of a clock distribution tree.

A level-sensitive `sync` input holds the divider in reset with its output low. While it is held, the phase field is loaded into the counter. The first rising input edge that samples `sync` low starts counting from that loaded phase. Several dividers fed by the same input clock and released on the same edge therefore come up in a fixed phase relation to one another, and that relation repeats at the greatest common divisor of their output frequencies. A power-down input holds the divider in the same way. Clearing it acts as a release. Configuration is loaded through a write strobe that is sampled on the selected clock.

Top module: `phase_clock_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. Reset sets the ratio register to the parameter `RATIO_RST` (default 4) and the phase register to 0. The first rising edge of the selected clock after reset is removed, with `sync` and `pwr_dn` low, acts as a release.
- R2: A ratio register value r from 1 to 63 gives an output period of r input periods. The value 0 gives 64 input periods.
- R3: The output is high for exactly N half input periods out of every 2N, where N is the effective ratio. This holds for odd N too.
- R4: After a release, `clk_out` stays low for p half input periods, where p is the phase register value. It then rises, so each phase unit delays the first rising edge by half an input period.
- R5: On every rising edge of the selected clock that samples `sync` high, the divider is held: `clk_out` is low for the whole following input period.
- R6: Counting from the release edge as half-period index 0, `clk_out` is high in half period h exactly when h ≥ p and ((h − p) mod 2N) < N. The same configuration and release timing always give the same waveform.
- R7: Writing a new phase value while the divider runs leaves the running output unchanged. The new value applies only after the next release.
- R8: While `pwr_dn` is sampled high, `clk_out` is low and the counter is held. Clearing `pwr_dn` acts as a release, using the stored phase.
- R9: `src_sel` = 0 selects `clk_a` and `src_sel` = 1 selects `clk_b`. The divider, the configuration register and the `sync` sampling all run on the selected clock.
- R10: When `cfg_wr` is high on a rising edge of the selected clock, `cfg_ratio` and `cfg_phase` are stored.
- R11: With a ratio of 1, `clk_out` follows the selected clock when p is even, and its inverse when p is odd, once the phase delay has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_a | input | 1 | First input clock (source 0) |
| clk_b | input | 1 | Second input clock (source 1) |
| src_sel | input | 1 | Input clock choice: 0 = clk_a, 1 = clk_b |
| cfg_wr | input | 1 | Load strobe for ratio and phase |
| cfg_ratio | input | 6 | Divide ratio, 0 means 64 |
| cfg_phase | input | 6 | Initial phase delay in half input periods |
| sync | input | 1 | Level hold; the falling level releases the divider |
| pwr_dn | input | 1 | Stops the divider and holds the output low |
| clk_out | output | 1 | Divided clock |

## Verification
The release edge is the first rising edge of the selected clock that samples `sync` or `pwr_dn` low. The value for half period 0 is registered on that edge. The value for half period 1 is registered on the falling edge that follows it, so each output level appears within the half period it belongs to, with no added latency. The bench records the time of that release edge and samples `clk_out` a quarter period into each half period. It derives the half-period index from the elapsed time and compares the output with the R6 formula. A held state shows on `clk_out` starting with the input period that follows the rising edge that samples it, and a configuration write lands on the rising edge that samples the strobe. Hold and write checks are therefore sampled only after that edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // signed half-period position relative to the first high half period
    typedef logic signed [15:0] hpos_t;

    function automatic logic level_at(hpos_t pos, hpos_t high_len);
        return (pos >= 0) && (pos < high_len);
    endfunction

    function automatic hpos_t step(hpos_t pos, hpos_t inc, hpos_t span);
        hpos_t t;
        t = pos + inc;
        if (t >= span) t = t - span;
        return t;
    endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/1ps
module clkdiv_src_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic src_sel,
    output logic clk_sel
);
    assign clk_sel = src_sel ? clk_b : clk_a;
endmodule

// File: rtl/clkdiv_cfg.sv
`timescale 1ns/1ps
module clkdiv_cfg #(
    parameter int RATIO_W   = 6,
    parameter int PHASE_W   = 6,
    parameter int RATIO_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [PHASE_W-1:0] phase_in,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [PHASE_W-1:0] phase_q
);
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [PHASE_W-1:0] phase;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr) begin
            c_d.ratio = ratio_in;
            c_d.phase = phase_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.ratio <= RATIO_W'(RATIO_RST);
            c_q.phase <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign ratio_q = c_q.ratio;
    assign phase_q = c_q.phase;
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [PHASE_W-1:0] phase,
    output logic               hi_o,
    output logic               lo_o,
    output logic               act_o
);
    localparam int FULL_RATIO = 1 << RATIO_W;

    typedef struct packed {
        hpos_t pos;
        logic  act;
        logic  hi;
    } st_t;

    st_t   s_d, s_q;
    logic  lo_d, lo_q;
    hpos_t high_len, span;

    always_comb begin
        high_len = (ratio == '0) ? hpos_t'(FULL_RATIO) : hpos_t'(ratio);
        span     = high_len + high_len;
        s_d      = s_q;
        if (hold) begin
            s_d.pos = -hpos_t'(phase);
            s_d.act = 1'b0;
            s_d.hi  = 1'b0;
        end else if (!s_q.act) begin
            s_d.act = 1'b1;
            s_d.hi  = level_at(s_q.pos, high_len);
        end else begin
            s_d.pos = step(s_q.pos, hpos_t'(2), span);
            s_d.hi  = level_at(s_d.pos, high_len);
        end
        lo_d = s_q.act ? level_at(step(s_q.pos, hpos_t'(1), span), high_len) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pos <= '0;
            s_q.act <= 1'b0;
            s_q.hi  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lo_q <= 1'b0;
        else        lo_q <= lo_d;
    end

    assign hi_o  = s_q.hi;
    assign lo_o  = lo_q;
    assign act_o = s_q.act;
endmodule

// File: rtl/phase_clock_divider.sv
`timescale 1ns/1ps
module phase_clock_divider #(
    parameter int RATIO_W   = 6,
    parameter int PHASE_W   = 6,
    parameter int RATIO_RST = 4
) (
    input  logic               rst_n,
    input  logic               clk_a,
    input  logic               clk_b,
    input  logic               src_sel,
    input  logic               cfg_wr,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic               sync,
    input  logic               pwr_dn,
    output logic               clk_out
);
    logic               clk_sel;
    logic [RATIO_W-1:0] ratio_q;
    logic [PHASE_W-1:0] phase_q;
    logic               hi_q, lo_q, act_q;

    clkdiv_src_mux u_mux (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .src_sel (src_sel),
        .clk_sel (clk_sel)
    );

    clkdiv_cfg #(
        .RATIO_W   (RATIO_W),
        .PHASE_W   (PHASE_W),
        .RATIO_RST (RATIO_RST)
    ) u_cfg (
        .clk      (clk_sel),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .ratio_in (cfg_ratio),
        .phase_in (cfg_phase),
        .ratio_q  (ratio_q),
        .phase_q  (phase_q)
    );

    clkdiv_core #(
        .RATIO_W (RATIO_W),
        .PHASE_W (PHASE_W)
    ) u_core (
        .clk   (clk_sel),
        .rst_n (rst_n),
        .hold  (sync | pwr_dn),
        .ratio (ratio_q),
        .phase (phase_q),
        .hi_o  (hi_q),
        .lo_o  (lo_q),
        .act_o (act_q)
    );

    // high half of the input period shows the rising-edge flop, low half the falling-edge flop
    assign clk_out = clk_sel ? hi_q : lo_q;
endmodule

// File: rtl/phase_clock_divider_chk.sv
`timescale 1ns/1ps
module phase_clock_divider_chk #(
    parameter int RATIO_W = 6,
    parameter int PHASE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync,
    input logic               pwr_dn,
    input logic               cfg_wr,
    input logic [RATIO_W-1:0] cfg_ratio,
    input logic [PHASE_W-1:0] cfg_phase,
    input logic [RATIO_W-1:0] ratio_q,
    input logic [PHASE_W-1:0] phase_q,
    input logic               hi,
    input logic               lo,
    input logic               act
);
    // R5: a sampled hold forces the high-phase level low
    a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !hi);

    // R8: power-down stops the counter and the output
    a_r8_pd_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!hi && !act));

    // R6: the first edge with no hold starts counting
    a_r6_release_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && !pwr_dn && !act) |=> act);

    // R6: a running divider stays running without a hold
    a_r6_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !sync && !pwr_dn) |=> act);

    // R10: a write strobe stores both fields
    a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ratio_q == $past(cfg_ratio) && phase_q == $past(cfg_phase)));

    // R8: when held, the low-phase flop also reads low in that same period
    a_r8_lo_quiet: assert property (@(negedge clk) disable iff (!rst_n)
        (!act && $stable(act)) |=> !lo);
endmodule

bind phase_clock_divider phase_clock_divider_chk #(
    .RATIO_W (RATIO_W),
    .PHASE_W (PHASE_W)
) u_chk (
    .clk       (clk_sel),
    .rst_n     (rst_n),
    .sync      (sync),
    .pwr_dn    (pwr_dn),
    .cfg_wr    (cfg_wr),
    .cfg_ratio (cfg_ratio),
    .cfg_phase (cfg_phase),
    .ratio_q   (ratio_q),
    .phase_q   (phase_q),
    .hi        (hi_q),
    .lo        (lo_q),
    .act       (act_q)
);

// File: tb/phase_clock_divider_test.sv
`timescale 1ns/1ps
module phase_clock_divider_test;
    localparam int CLK_A_PERIOD = 20;
    localparam int CLK_B_PERIOD = 28;

    logic       rst_n = 1'b0;
    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       src_sel = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_ratio = '0;
    logic [5:0] cfg_phase = '0;
    logic       sync = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       clk_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    time t0 = 0;

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    phase_clock_divider uut (
        .rst_n     (rst_n),
        .clk_a     (clk_a),
        .clk_b     (clk_b),
        .src_sel   (src_sel),
        .cfg_wr    (cfg_wr),
        .cfg_ratio (cfg_ratio),
        .cfg_phase (cfg_phase),
        .sync      (sync),
        .pwr_dn    (pwr_dn),
        .clk_out   (clk_out)
    );

    // ratio, phase, source, expected effective divide
    typedef struct packed {
        logic [5:0] ratio;
        logic [5:0] phase;
        logic       src;
        logic [6:0] eff;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{6'd4,  6'd0,  1'b0, 7'd4},
        '{6'd1,  6'd0,  1'b0, 7'd1},
        '{6'd1,  6'd1,  1'b0, 7'd1},
        '{6'd3,  6'd0,  1'b0, 7'd3},
        '{6'd3,  6'd5,  1'b0, 7'd3},
        '{6'd5,  6'd23, 1'b0, 7'd5},
        '{6'd0,  6'd2,  1'b0, 7'd64},
        '{6'd2,  6'd1,  1'b1, 7'd2},
        '{6'd7,  6'd3,  1'b1, 7'd7}
    };

    function automatic int half_p();
        return (src_sel ? CLK_B_PERIOD : CLK_A_PERIOD) / 2;
    endfunction

    function automatic logic expect_level(longint h, int div, int ph);
        if (h < ph) return 1'b0;
        return ((h - ph) % (2 * div)) < div;
    endfunction

    task automatic pos_edge();
        if (src_sel) @(posedge clk_b); else @(posedge clk_a);
    endtask

    task automatic neg_edge();
        if (src_sel) @(negedge clk_b); else @(negedge clk_a);
    endtask

    task automatic check_val(string tag, logic exp_v);
        n_cmp++;
        if (clk_out !== exp_v) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, clk_out, exp_v);
        end
    endtask

    task automatic check_now(string tag, int div, int ph);
        longint h;
        h = longint'($time - t0) / half_p();
        check_val(tag, expect_level(h, div, ph));
    endtask

    // sample half periods first..first+count-1 counted from the release edge
    task automatic stream(string tag, int div, int ph, longint first, int count);
        for (int i = 0; i < count; i++) begin
            time target;
            target = t0 + time'((first + i) * half_p() + half_p() / 2);
            #(target - $time);
            check_now(tag, div, ph);
        end
    endtask

    function automatic longint next_half();
        return longint'($time - t0) / half_p() + 1;
    endfunction

    task automatic write_cfg(int r, int p);
        neg_edge();
        cfg_wr = 1'b1; cfg_ratio = 6'(r); cfg_phase = 6'(p);
        neg_edge();
        cfg_wr = 1'b0;
    endtask

    task automatic release_sync();
        neg_edge();
        sync = 1'b1;
        pos_edge();
        #(half_p() / 2) check_val("R5 sync held, high half", 1'b0);
        neg_edge();
        #(half_p() / 2) check_val("R5 sync held, low half", 1'b0);
        neg_edge();
        sync = 1'b0;
        pos_edge();
        t0 = $time;
    endtask

    initial begin
        #(CLK_A_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: output low while in reset
        #(CLK_A_PERIOD/4)     check_val("R1 reset low", 1'b0);
        #(CLK_A_PERIOD/2)     check_val("R1 reset low", 1'b0);
        #(CLK_A_PERIOD)       check_val("R1 reset low", 1'b0);
        @(negedge clk_a) rst_n = 1'b1;
        @(posedge clk_a) t0 = $time;
        // R1: default ratio 4, phase 0, first edge acts as a release
        stream("R1 default divide by 4", 4, 0, 0, 24);

        // main table: R2 R3 R4 R6 R9 R10 R11
        for (int v = 0; v < 9; v++) begin
            neg_edge();
            sync = 1'b1;
            pos_edge();
            neg_edge();
            src_sel = VECS[v].src;
            write_cfg(int'(VECS[v].ratio), int'(VECS[v].phase));
            release_sync();
            stream(VECS[v].src ? "R9 R2 R3 R6 clk_b source" :
                   (VECS[v].eff == 1 ? "R11 R4 ratio one" : "R2 R3 R4 R6 R10 divide"),
                   int'(VECS[v].eff), int'(VECS[v].phase), 0,
                   int'(VECS[v].phase) + 4 * int'(VECS[v].eff));
        end

        // R7: phase rewrite while running changes nothing until the next release
        neg_edge();
        sync = 1'b1;
        pos_edge();
        neg_edge();
        src_sel = 1'b0;
        write_cfg(3, 0);
        release_sync();
        stream("R7 before rewrite", 3, 0, 0, 12);
        write_cfg(3, 4);
        stream("R7 after rewrite, no sync", 3, 0, next_half(), 18);
        release_sync();
        stream("R7 new phase after sync", 3, 4, 0, 16);

        // R8: power-down holds the output low, clearing it releases with stored phase
        neg_edge();
        pwr_dn = 1'b1;
        pos_edge();
        for (int k = 0; k < 4; k++) begin
            #(half_p() / 2) check_val("R8 powered down", 1'b0);
            neg_edge();
        end
        pwr_dn = 1'b0;
        pos_edge();
        t0 = $time;
        stream("R8 release from power-down", 3, 4, 0, 16);

        // R10 R2: ratio 0 written after run reaches 64-cycle period
        write_cfg(0, 0);
        release_sync();
        stream("R2 R10 ratio field zero", 64, 0, 0, 140);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule